// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block watches an SMBus clock line and flags bus timing violations. Three limits are checked at once. The first is a limit on one unbroken low period of SCL. The second is a limit on the total clock-low extension time in a message when the device is the bus controller. The third is a looser extension limit that applies when the device is a target. All limits are counted in ticks. A tick comes from the system clock divided by a parameterised prescale, so the default values give millisecond ticks and a bench can use a small divider.

When any limit is crossed, a sticky timeout flag is set and a one-cycle action request is issued. In controller mode the request asks the bus engine to send a STOP. In target mode it asks for the transfer to be reset and both lines released. Software clears the flag by writing zero. Dropping the peripheral enable also clears the flag and all counting state. The STOP generator and the line drivers sit outside this block.

Top module: `smbus_low_timeout`

## Requirements
- R1: While `enable` is 1 and `scl_in` stays 0, each tick adds one to a continuous-low count. When that count reaches `LOW_LIMIT`, `timeout_flag` becomes 1 on the next clock edge.
- R2: A clock edge with `scl_in` at 1 resets the continuous-low count to zero, so a low period that is broken by any high cycle starts again from zero.
- R3: With `slave_mode` at 0, each tick with `ext_active` at 1 adds to an extension total. When the total exceeds `MEXT_LIMIT`, `timeout_flag` becomes 1 on the next edge.
- R4: With `slave_mode` at 1, the same extension total sets `timeout_flag` when it exceeds `SEXT_LIMIT`.
- R5: The extension total keeps its value while `ext_active` is 0. A clock edge with `start_det` or `stop_det` at 1 resets it to zero.
- R6: A violation that starts with `slave_mode` at 0 pulses `stop_req` for exactly one cycle, in the same cycle the flag sets. `release_req` stays 0.
- R7: A violation that starts with `slave_mode` at 1 pulses `release_req` for exactly one cycle. `stop_req` stays 0.
- R8: A cycle with `flag_wr0` at 1 clears `timeout_flag` on the next edge. A violation that is still present does not set the flag again; only a new violation does.
- R9: While `enable` is 0, the flag, both counts and the prescaler are held at zero, and no request is issued.
- R10: A tick occurs once every `PRESCALE` clock cycles. The count of cycles restarts from zero when `enable` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Peripheral enable; 0 clears all state |
| scl_in | input | 1 | Sampled SCL level |
| slave_mode | input | 1 | 1 = target mode, 0 = controller mode |
| start_det | input | 1 | START condition seen (one cycle) |
| stop_det | input | 1 | STOP condition seen (one cycle) |
| ext_active | input | 1 | This device is currently stretching the clock low |
| flag_wr0 | input | 1 | Software write of 0 to the timeout flag |
| timeout_flag | output | 1 | Sticky timeout indication |
| stop_req | output | 1 | One-cycle STOP request (controller mode) |
| release_req | output | 1 | One-cycle reset-and-release request (target mode) |

## Verification
The hardest cases are the ones where the extension total has to survive gaps, or has to be wiped partway through, without the continuous-low counter firing first. The stimulus keeps `scl_in` high and toggles `ext_active` in separate windows, or inserts a single-cycle START or STOP once the total is close to the limit. Every scenario re-arms from a disabled state, so the prescaler phase is known. This lets each flag transition be checked on its exact edge, one edge before and one edge after the threshold.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  // Limit that applies to the extension total in the given mode.
  function automatic int ext_limit(input logic slave, input int mlim, input int slim);
    return slave ? slim : mlim;
  endfunction

  // Continuous-low violation: count has reached the limit.
  function automatic logic low_over(input int cnt, input int lim);
    return cnt >= lim;
  endfunction

  // Extension violation: total has gone past the limit.
  function automatic logic ext_over(input int cnt, input int lim);
    return cnt > lim;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/smbto_tick_div.sv
module smbto_tick_div #(
  parameter int PRESCALE = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = en;
    end else begin : g_div
      localparam int W = $clog2(PRESCALE);
      logic [W-1:0] div_q;
      logic         wrap;
      assign wrap = (div_q == W'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (!en)    div_q <= '0;
        else if (wrap)   div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end
      assign tick = en && wrap;

      // R10: ticks never come on back-to-back cycles when dividing
      a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/smbto_low_cnt.sv
module smbto_low_cnt #(
  parameter int LOW_LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic scl_in,
  output logic over
);
  import smbto_pkg::*;
  localparam int W = $clog2(LOW_LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cnt_q <= '0;
    else if (!en || scl_in)                        cnt_q <= '0;
    else if (tick && (int'(cnt_q) < LOW_LIMIT))    cnt_q <= cnt_q + 1'b1;
  end

  assign over = low_over(int'(cnt_q), LOW_LIMIT);

  // R1: count saturates at the limit
  a_r1_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= LOW_LIMIT);
  // R2: a high clock level wipes any pending violation
  a_r2_high_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scl_in) |=> !over);
endmodule

// File: rtl/smbto_ext_acc.sv
module smbto_ext_acc #(
  parameter int MEXT_LIMIT = 10,
  parameter int SEXT_LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic ext_active,
  input  logic start_det,
  input  logic stop_det,
  input  logic slave_mode,
  output logic over
);
  import smbto_pkg::*;
  localparam int SAT = max2(MEXT_LIMIT, SEXT_LIMIT) + 1;
  localparam int W   = $clog2(SAT + 1);
  logic [W-1:0] tot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        tot_q <= '0;
    else if (!en || start_det || stop_det)             tot_q <= '0;
    else if (tick && ext_active && (int'(tot_q) < SAT)) tot_q <= tot_q + 1'b1;
  end

  assign over = ext_over(int'(tot_q), ext_limit(slave_mode, MEXT_LIMIT, SEXT_LIMIT));

  // R5: a START or STOP leaves the total empty
  a_r5_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (tot_q == '0));
  // R5: the total does not move without an active extension
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ext_active && !start_det && !stop_det) |=> $stable(tot_q));
endmodule

// File: rtl/smbus_low_timeout.sv
module smbus_low_timeout #(
  parameter int PRESCALE   = 50000,
  parameter int LOW_LIMIT  = 25,
  parameter int MEXT_LIMIT = 10,
  parameter int SEXT_LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_in,
  input  logic slave_mode,
  input  logic start_det,
  input  logic stop_det,
  input  logic ext_active,
  input  logic flag_wr0,
  output logic timeout_flag,
  output logic stop_req,
  output logic release_req
);
  logic tick;
  logic low_viol;
  logic ext_viol;
  logic viol;
  logic viol_q;
  logic viol_rise;

  smbto_tick_div #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick));

  smbto_low_cnt #(.LOW_LIMIT(LOW_LIMIT)) u_low (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick),
    .scl_in(scl_in), .over(low_viol));

  smbto_ext_acc #(.MEXT_LIMIT(MEXT_LIMIT), .SEXT_LIMIT(SEXT_LIMIT)) u_ext (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick),
    .ext_active(ext_active), .start_det(start_det), .stop_det(stop_det),
    .slave_mode(slave_mode), .over(ext_viol));

  assign viol      = low_viol || ext_viol;
  assign viol_rise = viol && !viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q       <= 1'b0;
      timeout_flag <= 1'b0;
      stop_req     <= 1'b0;
      release_req  <= 1'b0;
    end else if (!enable) begin
      viol_q       <= 1'b0;
      timeout_flag <= 1'b0;
      stop_req     <= 1'b0;
      release_req  <= 1'b0;
    end else begin
      viol_q      <= viol;
      stop_req    <= viol_rise && !slave_mode;
      release_req <= viol_rise && slave_mode;
      if (viol_rise)     timeout_flag <= 1'b1;
      else if (flag_wr0) timeout_flag <= 1'b0;
    end
  end

  // R6: STOP requests only follow a controller-mode cycle
  a_r6_stop_master: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(!slave_mode));
  // R6: STOP request lasts one cycle
  a_r6_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);
  // R7: release requests only follow a target-mode cycle
  a_r7_release_slave: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |-> $past(slave_mode));
  // R7: release request lasts one cycle
  a_r7_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |=> !release_req);
  // R6/R7: a request always comes with the flag set
  a_r6_req_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req || release_req) |-> timeout_flag);
  // R9: disabling clears the flag
  a_r9_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!timeout_flag && !stop_req && !release_req));
  // R8: the flag only rises together with a request
  a_r8_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $onehot0({stop_req, release_req}) && (stop_req || release_req));
endmodule

// File: tb/smbus_low_timeout_test.sv
module smbus_low_timeout_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, scl_in = 1'b1, slave_mode = 1'b0;
  logic start_det = 1'b0, stop_det = 1'b0, ext_active = 1'b0, flag_wr0 = 1'b0;
  logic timeout_flag, stop_req, release_req;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // PRESCALE=4 -> ticks counted at edges 4,8,12,... after enable rises
  smbus_low_timeout #(.PRESCALE(4), .LOW_LIMIT(25), .MEXT_LIMIT(10), .SEXT_LIMIT(25)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
    .slave_mode(slave_mode), .start_det(start_det), .stop_det(stop_det),
    .ext_active(ext_active), .flag_wr0(flag_wr0),
    .timeout_flag(timeout_flag), .stop_req(stop_req), .release_req(release_req));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Clear everything with one disabled edge, then enable with given stimulus.
  task automatic arm(input logic scl, input logic ext, input logic slv);
    enable = 1'b0; scl_in = 1'b1; ext_active = 1'b0;
    start_det = 1'b0; stop_det = 1'b0; flag_wr0 = 1'b0;
    edges(1);
    scl_in = scl; ext_active = ext; slave_mode = slv; enable = 1'b1;
  endtask

  task automatic t_reset;
    chk("R9 reset flag", timeout_flag, 1'b0);
    chk("R9 reset stop", stop_req, 1'b0);
    chk("R9 reset release", release_req, 1'b0);
  endtask

  task automatic t_low_master;
    arm(1'b0, 1'b0, 1'b0);
    edges(100);
    chk("R1/R10 before limit", timeout_flag, 1'b0);
    edges(1);
    chk("R1 low limit flag", timeout_flag, 1'b1);
    chk("R6 stop pulse", stop_req, 1'b1);
    chk("R6 no release", release_req, 1'b0);
    edges(1);
    chk("R6 stop one cycle", stop_req, 1'b0);
    chk("R1 flag sticky", timeout_flag, 1'b1);
  endtask

  task automatic t_low_restart;
    arm(1'b0, 1'b0, 1'b0);
    edges(80);
    scl_in = 1'b1;
    edges(1);
    scl_in = 1'b0;
    edges(69);
    chk("R2 restart no early flag", timeout_flag, 1'b0);
    edges(30);
    chk("R2 before new limit", timeout_flag, 1'b0);
    edges(1);
    chk("R2 flag after full new period", timeout_flag, 1'b1);
  endtask

  task automatic t_ext_master;
    arm(1'b1, 1'b1, 1'b0);
    edges(44);
    chk("R3 at limit no flag", timeout_flag, 1'b0);
    edges(1);
    chk("R3 exceed flag", timeout_flag, 1'b1);
    chk("R6 stop on ext", stop_req, 1'b1);
  endtask

  task automatic t_ext_slave;
    arm(1'b1, 1'b1, 1'b1);
    edges(104);
    chk("R4 at slave limit no flag", timeout_flag, 1'b0);
    edges(1);
    chk("R4 exceed flag", timeout_flag, 1'b1);
    chk("R7 release pulse", release_req, 1'b1);
    chk("R7 no stop", stop_req, 1'b0);
    edges(1);
    chk("R7 release one cycle", release_req, 1'b0);
  endtask

  task automatic t_ext_cumulative;
    arm(1'b1, 1'b1, 1'b0);
    edges(20);
    ext_active = 1'b0;
    edges(20);
    ext_active = 1'b1;
    edges(24);
    chk("R5 cumulative before limit", timeout_flag, 1'b0);
    edges(1);
    chk("R5 cumulative across gap", timeout_flag, 1'b1);
  endtask

  task automatic t_ext_frame_clear(input bit use_stop);
    arm(1'b1, 1'b1, 1'b0);
    edges(40);
    if (use_stop) stop_det = 1'b1; else start_det = 1'b1;
    edges(1);
    start_det = 1'b0; stop_det = 1'b0;
    edges(43);
    chk(use_stop ? "R5 stop clears total" : "R5 start clears total", timeout_flag, 1'b0);
    edges(1);
    chk("R5 flag after fresh total", timeout_flag, 1'b1);
  endtask

  task automatic t_clear_and_disable;
    arm(1'b1, 1'b1, 1'b0);
    edges(50);
    chk("R8 precondition", timeout_flag, 1'b1);
    flag_wr0 = 1'b1;
    edges(1);
    flag_wr0 = 1'b0;
    chk("R8 write0 clears", timeout_flag, 1'b0);
    edges(10);
    chk("R8 persisting violation no reset", timeout_flag, 1'b0);
    chk("R8 no new stop", stop_req, 1'b0);
    arm(1'b0, 1'b0, 1'b0);
    edges(110);
    chk("R9 precondition", timeout_flag, 1'b1);
    enable = 1'b0;
    edges(1);
    chk("R9 disable clears flag", timeout_flag, 1'b0);
    edges(200);
    chk("R9 no counting while off", timeout_flag, 1'b0);
    scl_in = 1'b1; enable = 1'b1;
    edges(10);
    chk("R9 counts cleared on re-enable", timeout_flag, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_low_master();
    t_low_restart();
    t_ext_master();
    t_ext_slave();
    t_ext_cumulative();
    t_ext_frame_clear(1'b0);
    t_ext_frame_clear(1'b1);
    t_clear_and_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule